// File: doc/BRIEF.md
# Half-Duplex Serial Flash Command Engine

This block is a memory-mapped serial host that runs one flash-style command each time software triggers it. Software programs an 8-bit command opcode, a count of outgoing data bytes, a count of incoming data bytes and a two-bit target selector. It then places the outgoing bytes in a small byte buffer and sets the start bit. The engine pulls the selected chip-select line low and shifts out the opcode followed by the buffered bytes. Once every outgoing bit has left, it clocks in the requested number of bytes and stores them in the same buffer, directly behind the outgoing data.

The host bus is byte-wide. Read data comes from a register and appears one clock after the address. While a command runs, the engine owns the buffer and the configuration is frozen. A running flag lets software poll for completion. The serial side uses clock mode 0, sends and receives the most significant bit first, and runs the serial clock at a quarter of the system clock.

Top module: `sflash_cmd_engine`

## Requirements
- R1: After reset, every chip-select line is high, SCLK and MOSI are low, and every register reads 0.
- R2: The opcode reads back at offset 0x00, the outgoing count at 0x48 and the incoming count at 0x4B. The target selector is in bits 1:0 of offset 0x1D, and the other bits of that byte read 0. Buffer byte i is at offset 0x80+i. Read data is valid one clock after the address is presented.
- R3: Each command shifts the opcode out first, MSB first, in clock mode 0. MOSI changes only while SCLK is low, and SCLK has a period of 4 system clocks.
- R4: After a pointer clear, the outgoing bytes are taken from buffer positions 0 to txcount-1 in ascending order and sent straight after the opcode.
- R5: Incoming bytes are sampled only after all outgoing bits, with MOSI held low meanwhile. They are stored at buffer positions txcount to txcount+rxcount-1.
- R6: Writing 1 to bit 0 of offset 0x02 starts a command. While it runs, bit 0 of 0x02 and bit 7 of 0x03 read 1. Both return to 0 by themselves when it ends.
- R7: During a command, only chip-select line k (active low) is driven low, where k is the selector value. It stays low across all bytes and rises 4 system clocks after the last SCLK falling edge.
- R8: While a command runs, writes to the opcode, counts, selector, buffer and control bits are ignored.
- R9: Writing 1 to bit 4 of offset 0x02 resets the buffer pointer to 0. Without that write, the next command continues at the position where the previous one stopped.
- R10: A command produces exactly 8×(1+txcount+rxcount) SCLK rising edges, and a command with both counts zero sends only the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe for bus_wdata at bus_addr |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the address of the previous cycle |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the target |
| spi_miso | input | 1 | Serial data from the target |
| spi_cs_n | output | CS_COUNT | Active-low chip selects, one per target |

## Verification
The bench builds the engine with FIFO_DEPTH set to 16 and four chip selects. This lets it fill and read back every buffer position and reach every selector value. It sweeps outgoing counts of 0, 1, 2, 3 and 5 against incoming counts of 0, 1, 2 and 4, so the empty command, the pure-write and pure-read commands, and mixed commands all run against a serial target model that checks every bit. Separate cases run a command with its pointer continuing from the previous one, and write every configuration field while a command is running.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  // Byte offsets decoded on the host bus
  localparam logic [7:0] OFS_OPCODE = 8'h00;
  localparam logic [7:0] OFS_CTRL   = 8'h02;
  localparam logic [7:0] OFS_STAT   = 8'h03;
  localparam logic [7:0] OFS_TARGET = 8'h1D;
  localparam logic [7:0] OFS_TXCNT  = 8'h48;
  localparam logic [7:0] OFS_RXCNT  = 8'h4B;

  // Bit positions inside the control and status bytes
  localparam int EXEC_BIT = 0;
  localparam int CLR_BIT  = 4;
  localparam int BUSY_BIT = 7;

  // System clocks per serial clock period
  localparam int SCLK_DIV = 4;
  localparam int PH_W     = $clog2(SCLK_DIV);

  typedef enum logic [2:0] {
    S_IDLE,
    S_OPC,
    S_TXLD,
    S_TXW,
    S_RXLD,
    S_RXW,
    S_TAIL
  } seq_state_t;
endpackage

// File: rtl/sfe_ram.sv
module sfe_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    q
);
  logic [7:0] mem [DEPTH];

  // Single port, read-before-write, registered output
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/sfe_shifter.sv
module sfe_shifter
  import sfe_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] din,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic       active,
  output logic [7:0] dout
);
  logic [PH_W-1:0] ph;
  logic [2:0]      bitc;
  logic [7:0]      sh;

  localparam logic [PH_W-1:0] PH_RISE = PH_W'(SCLK_DIV/2 - 1);
  localparam logic [PH_W-1:0] PH_FALL = PH_W'(SCLK_DIV - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= '0;
      bitc   <= '0;
      sh     <= '0;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
      done   <= 1'b0;
      active <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        ph     <= '0;
        bitc   <= '0;
        sh     <= din;
        mosi   <= din[7];
        sclk   <= 1'b0;
      end else if (active) begin
        ph <= ph + 1'b1;
        if (ph == PH_RISE) begin
          // rising edge: capture the incoming bit
          sclk <= 1'b1;
          sh   <= {sh[6:0], miso};
        end else if (ph == PH_FALL) begin
          // falling edge: present the next outgoing bit
          sclk <= 1'b0;
          if (bitc == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
            mosi   <= 1'b0;
          end else begin
            bitc <= bitc + 1'b1;
            mosi <= sh[7];
          end
        end
      end
    end
  end

  assign dout = sh;
endmodule

// File: rtl/sfe_sequencer.sv
module sfe_sequencer
  import sfe_pkg::*;
#(
  parameter int PTR_W    = 6,
  parameter int CS_COUNT = 4,
  parameter int CS_W     = $clog2(CS_COUNT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic                clr,
  input  logic [7:0]          opcode,
  input  logic [7:0]          txcnt,
  input  logic [7:0]          rxcnt,
  input  logic [CS_W-1:0]     csel,
  input  logic [7:0]          fifo_q,
  input  logic                sh_done,
  input  logic [7:0]          sh_dout,
  output logic                sh_start,
  output logic [7:0]          sh_din,
  output logic                ram_we,
  output logic [PTR_W-1:0]    ram_addr,
  output logic [7:0]          ram_wdata,
  output logic                busy,
  output logic [CS_COUNT-1:0] cs_n
);
  seq_state_t      state;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       tx_left;
  logic [7:0]       rx_left;
  logic [PH_W-1:0]  tail;

  localparam logic [PH_W-1:0] TAIL_END = PH_W'(SCLK_DIV - 2);

  always_comb begin
    sh_start = 1'b0;
    sh_din   = 8'h00;
    ram_we   = 1'b0;
    case (state)
      S_IDLE: begin
        sh_start = go;
        sh_din   = opcode;
      end
      S_TXLD: begin
        sh_start = 1'b1;
        sh_din   = fifo_q;
      end
      S_RXLD:  sh_start = 1'b1;
      S_RXW:   ram_we   = sh_done;
      default: ;
    endcase
  end

  assign ram_addr  = ptr;
  assign ram_wdata = sh_dout;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      ptr     <= '0;
      tx_left <= '0;
      rx_left <= '0;
      tail    <= '0;
      busy    <= 1'b0;
      cs_n    <= '1;
    end else begin
      case (state)
        S_IDLE: begin
          if (clr) ptr <= '0;
          if (go) begin
            tx_left <= txcnt;
            rx_left <= rxcnt;
            cs_n    <= ~(CS_COUNT'(1) << csel);
            busy    <= 1'b1;
            state   <= S_OPC;
          end
        end
        S_OPC, S_TXW: begin
          if (sh_done) begin
            if (tx_left != 8'd0)      state <= S_TXLD;
            else if (rx_left != 8'd0) state <= S_RXLD;
            else begin
              tail  <= '0;
              state <= S_TAIL;
            end
          end
        end
        S_TXLD: begin
          tx_left <= tx_left - 8'd1;
          ptr     <= ptr + 1'b1;
          state   <= S_TXW;
        end
        S_RXLD: state <= S_RXW;
        S_RXW: begin
          if (sh_done) begin
            ptr     <= ptr + 1'b1;
            rx_left <= rx_left - 8'd1;
            if (rx_left == 8'd1) begin
              tail  <= '0;
              state <= S_TAIL;
            end else begin
              state <= S_RXLD;
            end
          end
        end
        S_TAIL: begin
          if (tail == TAIL_END) begin
            cs_n  <= '1;
            busy  <= 1'b0;
            state <= S_IDLE;
          end else begin
            tail <= tail + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine
  import sfe_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CS_COUNT   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [7:0]          bus_addr,
  input  logic                bus_wr,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  output logic                spi_sclk,
  output logic                spi_mosi,
  input  logic                spi_miso,
  output logic [CS_COUNT-1:0] spi_cs_n
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int CS_W  = $clog2(CS_COUNT);
  localparam logic [7:0] DEPTH_B = 8'(FIFO_DEPTH);

  logic [7:0]      opc_q, txc_q, rxc_q;
  logic [CS_W-1:0] csel_q;
  logic            busy;
  logic            wr_ok, fifo_hit, go, clr;

  logic             sh_start, sh_done, sh_active;
  logic [7:0]       sh_din, sh_dout;
  logic             seq_we;
  logic [PTR_W-1:0] seq_addr;
  logic [7:0]       seq_wdata;

  logic             ram_we;
  logic [PTR_W-1:0] ram_addr;
  logic [7:0]       ram_wdata, ram_q;

  logic             rd_fifo_q;
  logic [7:0]       reg_rd_q;

  assign wr_ok    = bus_wr && !busy;
  assign fifo_hit = bus_addr[7] && ({1'b0, bus_addr[6:0]} < DEPTH_B);
  assign go       = wr_ok && (bus_addr == OFS_CTRL) && bus_wdata[EXEC_BIT];
  assign clr      = wr_ok && (bus_addr == OFS_CTRL) && bus_wdata[CLR_BIT];

  // Configuration registers, frozen while a command runs
  always_ff @(posedge clk) begin
    if (rst) begin
      opc_q  <= '0;
      txc_q  <= '0;
      rxc_q  <= '0;
      csel_q <= '0;
    end else if (wr_ok) begin
      case (bus_addr)
        OFS_OPCODE: opc_q  <= bus_wdata;
        OFS_TXCNT:  txc_q  <= bus_wdata;
        OFS_RXCNT:  rxc_q  <= bus_wdata;
        OFS_TARGET: csel_q <= bus_wdata[CS_W-1:0];
        default: ;
      endcase
    end
  end

  // Buffer port belongs to the engine while busy, to the bus otherwise
  assign ram_we    = busy ? seq_we    : (wr_ok && fifo_hit);
  assign ram_addr  = busy ? seq_addr  : bus_addr[PTR_W-1:0];
  assign ram_wdata = busy ? seq_wdata : bus_wdata;

  sfe_ram #(.DEPTH(FIFO_DEPTH)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .q     (ram_q)
  );

  sfe_sequencer #(.PTR_W(PTR_W), .CS_COUNT(CS_COUNT)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .clr       (clr),
    .opcode    (opc_q),
    .txcnt     (txc_q),
    .rxcnt     (rxc_q),
    .csel      (csel_q),
    .fifo_q    (ram_q),
    .sh_done   (sh_done),
    .sh_dout   (sh_dout),
    .sh_start  (sh_start),
    .sh_din    (sh_din),
    .ram_we    (seq_we),
    .ram_addr  (seq_addr),
    .ram_wdata (seq_wdata),
    .busy      (busy),
    .cs_n      (spi_cs_n)
  );

  sfe_shifter u_shift (
    .clk    (clk),
    .rst    (rst),
    .start  (sh_start),
    .din    (sh_din),
    .miso   (spi_miso),
    .sclk   (spi_sclk),
    .mosi   (spi_mosi),
    .done   (sh_done),
    .active (sh_active),
    .dout   (sh_dout)
  );

  // Registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_fifo_q <= 1'b0;
      reg_rd_q  <= '0;
    end else begin
      rd_fifo_q <= fifo_hit;
      case (bus_addr)
        OFS_OPCODE: reg_rd_q <= opc_q;
        OFS_CTRL:   reg_rd_q <= {7'b0, busy};
        OFS_STAT:   reg_rd_q <= {busy, 7'b0};
        OFS_TARGET: reg_rd_q <= {{(8-CS_W){1'b0}}, csel_q};
        OFS_TXCNT:  reg_rd_q <= txc_q;
        OFS_RXCNT:  reg_rd_q <= rxc_q;
        default:    reg_rd_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rd_fifo_q ? ram_q : reg_rd_q;
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker #(
  parameter int CS_COUNT = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                busy,
  input logic                spi_sclk,
  input logic                spi_mosi,
  input logic [CS_COUNT-1:0] spi_cs_n,
  input logic [7:0]          opc_q,
  input logic [7:0]          txc_q,
  input logic [7:0]          rxc_q,
  input logic                sh_start,
  input logic                sh_active
);
  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $countones(~spi_cs_n) <= 1); // R7

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (spi_cs_n == '1 && !spi_sclk)); // R1

  AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    spi_sclk |-> (spi_cs_n != '1)); // R7

  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_sclk) |-> $stable(spi_mosi)); // R3

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(opc_q) && $stable(txc_q) && $stable(rxc_q))); // R8

  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    sh_start |-> !sh_active); // R3
endmodule

bind sflash_cmd_engine sfe_checker #(.CS_COUNT(CS_COUNT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .spi_cs_n  (spi_cs_n),
  .opc_q     (opc_q),
  .txc_q     (txc_q),
  .rxc_q     (rxc_q),
  .sh_start  (sh_start),
  .sh_active (sh_active)
);

// File: tb/sflash_cmd_engine_tb.sv
`timescale 1ns/1ps
module sflash_cmd_engine_tb;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       spi_sclk, spi_mosi;
  logic       spi_miso = 1'b0;
  logic [3:0] spi_cs_n;

  always #2 clk = ~clk;

  sflash_cmd_engine #(.FIFO_DEPTH(DEPTH), .CS_COUNT(4)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  int  nvec = 0, nerr = 0;
  bit  finished = 1'b0;
  int  cur_tx = 0, cur_rx = 0, cur_k = 0;
  logic [3:0] exp_csn = 4'hF;
  logic [7:0] exp_tx [0:15];

  // serial target model state
  logic [7:0] got [0:15];
  int  bc = 0, slave_err = 0, per_err = 0;
  time t_fall = 0, t_rise = 0, t_lastrise = 0;
  logic sclk_d = 1'b0, cs_d = 1'b1;
  wire  cs_any = &spi_cs_n;

  function automatic logic [7:0] rxpat(int k, int j);
    return 8'((j * 29 + k * 7 + 165) & 255);
  endfunction

  function automatic logic miso_bit(int b);
    int first;
    logic [7:0] v;
    first = 8 * (1 + cur_tx);
    if (b < first || b >= first + 8 * cur_rx) return 1'b0;
    v = rxpat(cur_k, (b - first) / 8);
    return v[7 - ((b - first) % 8)];
  endfunction

  always @(spi_sclk or cs_any) begin
    if (cs_d === 1'b1 && cs_any === 1'b0) begin
      bc = 0;
      spi_miso = miso_bit(0);
    end
    if (sclk_d === 1'b0 && spi_sclk === 1'b1) begin
      if (bc < 128) got[bc / 8][7 - (bc % 8)] = spi_mosi;
      if (spi_cs_n !== exp_csn) slave_err++;
      if ((bc % 8) != 0 && ($time - t_lastrise) != 16) per_err++;
      t_lastrise = $time;
      bc++;
    end
    if (sclk_d === 1'b1 && spi_sclk === 1'b0) begin
      t_fall = $time;
      spi_miso = miso_bit(bc);
    end
    if (cs_d === 1'b0 && cs_any === 1'b1) t_rise = $time;
    sclk_d = spi_sclk;
    cs_d   = cs_any;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  int se0, pe0;

  task automatic start_xfer(input int opc, input int tx, input int rx,
                            input int cs, input int k, input bit clr,
                            input int txbase);
    logic [7:0] s;
    cur_tx = tx; cur_rx = rx; cur_k = k;
    exp_csn = ~(4'b0001 << cs);
    wr(8'h00, 8'(opc));
    wr(8'h48, 8'(tx));
    wr(8'h4B, 8'(rx));
    wr(8'h1D, 8'(cs));
    for (int i = 0; i < tx; i++) wr(8'(8'h80 + txbase + i), exp_tx[i]);
    se0 = slave_err; pe0 = per_err;
    wr(8'h02, clr ? 8'h11 : 8'h01);
    rd(8'h03, s); chk("R6 running flag in status byte", int'(s), 8'h80);
    rd(8'h02, s); chk("R6 start bit reads set while running", int'(s), 8'h01);
  endtask

  task automatic finish_xfer(input int opc, input int tx, input int rx,
                             input int rxbase);
    logic [7:0] s;
    int n;
    n = 0;
    do begin
      rd(8'h03, s);
      n++;
    end while (s[7] && n < 3000);
    chk("R6 command completes", int'(n >= 3000), 0);
    rd(8'h02, s); chk("R6 start bit self-clears", int'(s), 0);
    chk("R10 SCLK rising edge count", bc, 8 * (1 + tx + rx));
    chk("R3 opcode sent first MSB first", int'(got[0]), opc);
    for (int i = 0; i < tx; i++)
      chk($sformatf("R4 outgoing byte %0d", i), int'(got[1 + i]), int'(exp_tx[i]));
    for (int j = 0; j < rx; j++)
      chk($sformatf("R5 MOSI low in receive byte %0d", j), int'(got[1 + tx + j]), 0);
    chk("R7 only selected chip select low", slave_err - se0, 0);
    chk("R3 SCLK period of 4 clocks", per_err - pe0, 0);
    chk("R7 release 4 clocks after last fall", int'(t_rise - t_fall), 16);
    for (int j = 0; j < rx; j++) begin
      rd(8'(8'h80 + rxbase + j), s);
      chk($sformatf("R5 received byte %0d stored", j), int'(s), int'(rxpat(cur_k, j)));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nvec++; nerr++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    int txs [5] = '{0, 1, 2, 3, 5};
    int rxs [4] = '{0, 1, 2, 4};
    int k;

    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk("R1 chip selects idle high", int'(spi_cs_n), 15);
    chk("R1 SCLK low", int'(spi_sclk), 0);
    chk("R1 MOSI low", int'(spi_mosi), 0);
    rd(8'h00, s); chk("R1 opcode reset", int'(s), 0);
    rd(8'h02, s); chk("R1 control reset", int'(s), 0);
    rd(8'h03, s); chk("R1 status reset", int'(s), 0);
    rd(8'h1D, s); chk("R1 selector reset", int'(s), 0);
    rd(8'h48, s); chk("R1 tx count reset", int'(s), 0);
    rd(8'h4B, s); chk("R1 rx count reset", int'(s), 0);

    // R2 register and buffer readback
    wr(8'h00, 8'hA7); rd(8'h00, s); chk("R2 opcode readback", int'(s), 8'hA7);
    wr(8'h48, 8'h3C); rd(8'h48, s); chk("R2 tx count readback", int'(s), 8'h3C);
    wr(8'h4B, 8'h05); rd(8'h4B, s); chk("R2 rx count readback", int'(s), 8'h05);
    wr(8'h1D, 8'hFF); rd(8'h1D, s); chk("R2 selector keeps bits 1:0", int'(s), 3);
    for (int i = 0; i < DEPTH; i++) wr(8'(8'h80 + i), 8'((i * 13 + 7) & 255));
    for (int i = 0; i < DEPTH; i++) begin
      rd(8'(8'h80 + i), s);
      chk($sformatf("R2 buffer byte %0d", i), int'(s), (i * 13 + 7) & 255);
    end

    // Sweep of outgoing and incoming counts (R3 R4 R5 R6 R7 R10)
    k = 0;
    foreach (txs[a]) begin
      foreach (rxs[b]) begin
        for (int i = 0; i < 16; i++) exp_tx[i] = 8'((i * 37 + k * 11 + 5) & 255);
        start_xfer((k * 53 + 11) & 255, txs[a], rxs[b], k % 4, k, 1'b1, 0);
        finish_xfer((k * 53 + 11) & 255, txs[a], rxs[b], txs[a]);
        k++;
      end
    end

    // R9 pointer continues without a clear
    for (int i = 0; i < 16; i++) exp_tx[i] = 8'((i * 41 + 3) & 255);
    start_xfer(8'h6B, 2, 1, 1, 40, 1'b1, 0);
    finish_xfer(8'h6B, 2, 1, 2);
    exp_tx[0] = 8'h5A; exp_tx[1] = 8'hC3;
    start_xfer(8'h0B, 2, 1, 2, 41, 1'b0, 3);
    finish_xfer(8'h0B, 2, 1, 5);
    chk("R9 first byte taken from position 3", int'(got[1]), 8'h5A);
    chk("R9 second byte taken from position 4", int'(got[2]), 8'hC3);

    // R8 writes while running are ignored
    for (int i = 0; i < 16; i++) exp_tx[i] = 8'((i * 19 + 99) & 255);
    start_xfer(8'h9F, 3, 2, 3, 50, 1'b1, 0);
    wr(8'h00, 8'hEE);
    wr(8'h48, 8'h09);
    wr(8'h4B, 8'h09);
    wr(8'h1D, 8'h02);
    wr(8'h80, 8'h77);
    wr(8'h02, 8'h11);
    finish_xfer(8'h9F, 3, 2, 3);
    rd(8'h00, s); chk("R8 opcode unchanged", int'(s), 8'h9F);
    rd(8'h48, s); chk("R8 tx count unchanged", int'(s), 3);
    rd(8'h4B, s); chk("R8 rx count unchanged", int'(s), 2);
    rd(8'h1D, s); chk("R8 selector unchanged", int'(s), 3);
    rd(8'h80, s); chk("R8 buffer byte unchanged", int'(s), int'(exp_tx[0]));
    repeat (20) @(negedge clk);
    rd(8'h03, s); chk("R8 start during run did not queue", int'(s), 0);
    chk("R8 chip selects stay idle", int'(spi_cs_n), 15);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule